// File: doc/BRIEF.md
# SPI Port Controller

This block is a serial peripheral port that sits on a small byte-wide register bus and talks to other devices over a four-wire SPI link. A single 8-bit shift register serves both roles. As bus master the block drives the serial clock and the outgoing data line. As slave it follows a clock from another device and is selected by an active-low select line. When a byte has been fully shifted, it is copied into a separate receive buffer. The CPU reads that buffer, so software sees a stable byte while the next one is being shifted.

Software sets the mode, the clock polarity and phase, and the master clock divider through the control register. It learns that a byte has arrived from a completion flag in the status register, or from an interrupt line. In master mode, writing a byte to the data register starts a transfer. In slave mode, the same write preloads the byte that goes back to the remote master.

Top module: `spi_port_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 0x00 and the status register reads 0x00. irq is 0, so the port starts disabled, in slave mode, with interrupts off.
- R2: The register map uses these addresses: 0 is control, 1 is status, 2 is data, and address 3 reads 0x00.
  - Control bits: bit7 interrupt enable, bit6 port enable, bit5 always reads 0, bit4 master select, bit3 clock polarity, bit2 clock phase, bits1:0 rate select.
  - Register reads appear on bus_rdata one clock after the read strobe.
- R3: In master mode, a data-register write loads the shift register and starts a transfer of 8 bits. Data goes out on mosi_o and comes in from miso_i, most significant bit first. When the byte is done, the received byte is in the read buffer.
- R4: The master serial clock half period is 1, 2, 8 or 16 system clocks, for rate select values 0, 1, 2 and 3.
- R5: The serial clock idles at the polarity bit. With phase 0, data is sampled on the first edge of each bit and changed on the second. With phase 1, data is changed on the first edge and sampled on the second.
- R6: Status bit7 is set when a byte enters the read buffer. It is cleared only by a status read made while the flag is set, followed by a data-register access. A data access without that earlier status read leaves the flag set.
- R7: irq is 1 exactly when interrupt enable and the completion flag are both set, with one clock of delay.
- R8: In slave mode with ss_n_i low, edges on sck_i shift mosi_i into the shift register. The preloaded byte is sent out on miso_o, most significant bit first, and the received byte goes to the read buffer after 8 bits.
- R9: In slave mode, activity on sck_i while ss_n_i is high changes neither the read buffer nor the completion flag.
- R10: Output enables depend on the mode:
  - Master: sck_oe and mosi_oe are 1.
  - Slave: miso_oe is 1 only while selected.
  - Disabled: no enable is 1.
  - sck_oe and miso_oe are never 1 together.
- R11: A data-register read during a transfer returns the previous received byte, not the partly shifted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from a remote master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Incoming data in slave mode |
| mosi_o | output | 1 | Outgoing data in master mode |
| mosi_oe | output | 1 | mosi output enable |
| miso_i | input | 1 | Incoming data in master mode |
| miso_o | output | 1 | Outgoing data in slave mode |
| miso_oe | output | 1 | miso output enable |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The assertions assume that clock polarity and clock phase are not rewritten while a byte is on the wire. They also assume that the remote serial clock is slow enough for the two-flop synchronizers, and that mosi_i stays steady for a few system clocks around each sampling edge. The bench keeps within these limits in three ways. It writes the control register only between transfers. It runs its remote master with a half period of six system clocks. It changes mosi_i only on the changing edge. As master peer, it updates miso_i half a clock after the changing edge that it observes on sck_o.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int CTL_W = 8;
  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic       ie;
    logic       en;
    logic       mst;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctl_t;

  // system clocks per serial clock half period
  function automatic int unsigned half_period(input logic [1:0] r);
    case (r)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= rst_val;
      q  <= rst_val;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'(half_period(rate) - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign tick = run && (cnt == lim);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          mst,
  input  logic          cpha,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          s_active,
  input  logic          s_lead,
  input  logic          s_trail,
  input  logic          s_ss_fall,
  input  logic          rx_m,
  input  logic          rx_s,
  output logic          busy,
  output logic          tog,
  output logic          tx_bit,
  output logic [DW-1:0] rbuf,
  output logic          done
);
  localparam int EW = $clog2(2 * DW);
  localparam int BW = $clog2(DW);

  logic [DW-1:0] sr;
  logic [EW-1:0] ecnt;
  logic [BW-1:0] bcnt;
  logic m_lead, m_trail, lead, trail, smp, chg, rx, m_last, s_last, accept;
  logic [DW-1:0] sr_shift;

  always_comb begin
    m_lead   = mst && busy && tick && !ecnt[0];
    m_trail  = mst && busy && tick && ecnt[0];
    lead     = m_lead  || (!mst && s_active && s_lead);
    trail    = m_trail || (!mst && s_active && s_trail);
    smp      = cpha ? trail : lead;
    chg      = cpha ? lead : trail;
    rx       = mst ? rx_m : rx_s;
    sr_shift = {sr[DW-2:0], rx};
    m_last   = m_trail && (ecnt == EW'(2 * DW - 1));
    s_last   = !mst && smp && (bcnt == BW'(DW - 1));
    done     = en && (m_last || s_last);
    accept   = wr && en && (mst ? !busy : (bcnt == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      ecnt   <= '0;
      bcnt   <= '0;
      busy   <= 1'b0;
      tog    <= 1'b0;
      tx_bit <= 1'b0;
      rbuf   <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      ecnt <= '0;
      bcnt <= '0;
      tog  <= 1'b0;
    end else begin
      if (accept) begin
        sr     <= wdata;
        tx_bit <= wdata[DW-1];
        if (mst) begin
          busy <= 1'b1;
          ecnt <= '0;
          tog  <= 1'b0;
        end
      end else begin
        if (smp) sr <= sr_shift;
        if (chg) tx_bit <= sr[DW-1];
        else if (s_ss_fall && !mst) tx_bit <= sr[DW-1];
      end
      if (mst && busy && tick) begin
        tog  <= ~tog;
        ecnt <= ecnt + EW'(1);
        if (m_last) busy <= 1'b0;
      end
      if (!mst) begin
        busy <= 1'b0;
        tog  <= 1'b0;
        if (!s_active) bcnt <= '0;
        else if (smp) bcnt <= (bcnt == BW'(DW - 1)) ? '0 : bcnt + BW'(1);
      end
      if (done) rbuf <= smp ? sr_shift : sr;
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  ctl_t          ctl_q;
  logic          done_flag, clr_armed;
  logic          wr_ctl, rd_stat, wr_data, data_acc;
  logic [2:0]    sync_q;
  logic          ss_s, sck_s, mosi_s, sck_p, ss_p;
  logic          s_active, s_lead, s_trail, s_ss_fall;
  logic          tick, busy, tog, tx_bit, xfer_done;
  logic [DW-1:0] rbuf, rd_mux;
  logic [CTL_W-1:0] ctl_byte;

  assign wr_ctl   = bus_sel && bus_wr && (bus_addr == A_CTL);
  assign rd_stat  = bus_sel && bus_rd && (bus_addr == A_STAT);
  assign wr_data  = bus_sel && bus_wr && (bus_addr == A_DATA);
  assign data_acc = bus_sel && (bus_wr || bus_rd) && (bus_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (wr_ctl)
      ctl_q <= '{ie: bus_wdata[7], en: bus_wdata[6], mst: bus_wdata[4],
                 cpol: bus_wdata[3], cpha: bus_wdata[2], rate: bus_wdata[1:0]};
  end

  spi_sync2 #(.W(3)) i_sync (
    .clk(clk), .rst(rst), .d({ss_n_i, sck_i, mosi_i}),
    .rst_val(3'b100), .q(sync_q)
  );
  assign {ss_s, sck_s, mosi_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= 1'b0;
      ss_p  <= 1'b1;
    end else begin
      sck_p <= sck_s;
      ss_p  <= ss_s;
    end
  end

  assign s_active  = ctl_q.en && !ctl_q.mst && !ss_s;
  assign s_lead    = (sck_s != sck_p) && (sck_s != ctl_q.cpol);
  assign s_trail   = (sck_s != sck_p) && (sck_s == ctl_q.cpol);
  assign s_ss_fall = !ss_s && ss_p;

  spi_rate_gen #(.CW(CW)) i_rate (
    .clk(clk), .rst(rst), .run(ctl_q.en && ctl_q.mst && busy),
    .rate(ctl_q.rate), .tick(tick)
  );

  spi_shift_engine #(.DW(DW)) i_eng (
    .clk(clk), .rst(rst), .en(ctl_q.en), .mst(ctl_q.mst), .cpha(ctl_q.cpha),
    .wr(wr_data), .wdata(bus_wdata), .tick(tick), .s_active(s_active),
    .s_lead(s_lead), .s_trail(s_trail), .s_ss_fall(s_ss_fall),
    .rx_m(miso_i), .rx_s(mosi_s), .busy(busy), .tog(tog), .tx_bit(tx_bit),
    .rbuf(rbuf), .done(xfer_done)
  );

  // completion flag with two-step clear
  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b0;
      clr_armed <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (xfer_done) done_flag <= 1'b1;
      else if (clr_armed && data_acc) done_flag <= 1'b0;
      if (rd_stat && done_flag) clr_armed <= 1'b1;
      else if (data_acc) clr_armed <= 1'b0;
      irq <= ctl_q.ie && done_flag;
    end
  end

  assign ctl_byte = {ctl_q.ie, ctl_q.en, 1'b0, ctl_q.mst,
                     ctl_q.cpol, ctl_q.cpha, ctl_q.rate};

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTL:   rd_mux[CTL_W-1:0] = ctl_byte;
      A_STAT:  rd_mux[7] = done_flag;
      A_DATA:  rd_mux = rbuf;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && bus_rd) bus_rdata <= rd_mux;
  end

  assign sck_o   = ctl_q.cpol ^ tog;
  assign sck_oe  = ctl_q.en && ctl_q.mst;
  assign mosi_o  = tx_bit;
  assign mosi_oe = ctl_q.en && ctl_q.mst;
  assign miso_o  = tx_bit;
  assign miso_oe = s_active;
endmodule

// File: rtl/spi_port_ctrl_chk.sv
module spi_port_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sck_oe,
  input logic          miso_oe,
  input logic          sck_o,
  input logic          irq,
  input logic          flag,
  input logic          ie,
  input logic          en,
  input logic          mst,
  input logic          busy,
  input logic          cpol,
  input logic [DW-1:0] rbuf,
  input logic          done
);
  AST_RST_CTL: assert property (@(posedge clk) rst |=> (!ie && !en && !mst)); // R1
  AST_PIN_DIR: assert property (@(posedge clk) disable iff (rst) !(sck_oe && miso_oe)); // R10
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst) irq == $past(ie && flag)); // R7
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst) ($fell(busy) && sck_oe) |-> (sck_o == cpol)); // R5
  AST_RBUF_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(rbuf) |-> $past(done)); // R11
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst) done |=> flag); // R6
endmodule

bind spi_port_ctrl spi_port_ctrl_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst(rst), .sck_oe(sck_oe), .miso_oe(miso_oe), .sck_o(sck_o),
  .irq(irq), .flag(done_flag), .ie(ctl_q.ie), .en(ctl_q.en), .mst(ctl_q.mst),
  .busy(busy), .cpol(ctl_q.cpol), .rbuf(rbuf), .done(xfer_done)
);

// File: tb/test_spi_port_ctrl.sv
`timescale 1ns/1ps
module test_spi_port_ctrl;
  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_n_i = 1;
  int cyc = 0, n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_port_ctrl i_spi_port_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i)
  );

  function automatic int exp_half(input logic [1:0] r);
    case (r) 2'd0: return 1; 2'd1: return 2; 2'd2: return 8; default: return 16; endcase
  endfunction

  function automatic logic [7:0] exp_ctl(input logic [7:0] w);
    return w & 8'hDF;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_sel = 0; bus_rd = 0; d = bus_rdata;
  endtask

  // bench acts as the remote slave and watches sck_o
  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] sb, input logic pol,
                        input logic ph, input logic [1:0] rt, input logic ie,
                        output logic [7:0] got, output int half);
    int edges, oidx, t0, t1, guard;
    logic prev, lead;
    edges = 0; t0 = 0; t1 = 0; guard = 0; got = '0;
    bwrite(2'd0, {ie, 1'b1, 1'b0, 1'b1, pol, ph, rt});
    prev = pol;
    if (!ph) begin miso_i = sb[7]; oidx = 1; end else oidx = 0;
    bwrite(2'd2, tx);
    while (edges < 16 && guard < 4000) begin
      @(negedge clk); guard++;
      if (sck_o !== prev) begin
        prev = sck_o;
        lead = (edges % 2 == 0);
        if (edges == 0) t0 = cyc;
        if (edges == 1) t1 = cyc;
        if (lead != ph) got = {got[6:0], mosi_o};
        else if (oidx < 8) begin miso_i = sb[7 - oidx]; oidx++; end
        edges++;
      end
    end
    half = t1 - t0;
    repeat (3) @(negedge clk);
  endtask

  task automatic m_case(input logic [7:0] tx, input logic [7:0] sb, input logic pol,
                        input logic ph, input logic [1:0] rt);
    logic [7:0] got, d;
    int half;
    m_xfer(tx, sb, pol, ph, rt, 1'b0, got, half);
    chk("R3 mosi byte", got, tx);
    chk("R5 sck idle", sck_o, pol);
    bread(2'd1, d); chk("R6 flag set", d, 8'h80);
    bread(2'd2, d); chk("R3 read buffer", d, sb);
  endtask

  // bench acts as the remote master
  task automatic s_xfer(input logic [7:0] pre, input logic [7:0] mb, input logic pol,
                        input logic ph, output logic [7:0] cap);
    cap = '0;
    bwrite(2'd0, {1'b0, 1'b1, 1'b0, 1'b0, pol, ph, 2'b00});
    sck_i = pol;
    repeat (4) @(negedge clk);
    bwrite(2'd2, pre);
    ss_n_i = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!ph) begin
        mosi_i = mb[7 - i];
        repeat (6) @(negedge clk);
        cap = {cap[6:0], miso_o}; sck_i = ~pol;
        repeat (6) @(negedge clk);
        sck_i = pol;
      end else begin
        repeat (6) @(negedge clk);
        sck_i = ~pol; mosi_i = mb[7 - i];
        repeat (6) @(negedge clk);
        cap = {cap[6:0], miso_o}; sck_i = pol;
      end
    end
    repeat (6) @(negedge clk);
    chk("R10 slave selected miso_oe", miso_oe, 1);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic s_case(input logic [7:0] pre, input logic [7:0] mb, input logic pol, input logic ph);
    logic [7:0] cap, d;
    s_xfer(pre, mb, pol, ph, cap);
    chk("R8 miso byte", cap, pre);
    bread(2'd1, d); chk("R8 flag", d, 8'h80);
    bread(2'd2, d); chk("R8 read buffer", d, mb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got;
    int half;
    void'($urandom(32'h1A2B3C4D));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    bread(2'd0, d); chk("R1 ctl reset", d, 8'h00);
    bread(2'd1, d); chk("R1 status reset", d, 8'h00);
    chk("R1 irq reset", irq, 0);
    chk("R10 disabled oe", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    // R2 map
    bwrite(2'd0, 8'hFF);
    bread(2'd0, d); chk("R2 ctl bit5 reads 0", d, exp_ctl(8'hFF));
    bread(2'd3, d); chk("R2 addr3 zero", d, 8'h00);
    chk("R10 master oe", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    bwrite(2'd0, 8'h00);
    // R3 R5 all four phase and polarity modes
    m_case(8'hA5, 8'h3C, 0, 0, 2'd0);
    m_case(8'h81, 8'h7E, 0, 1, 2'd1);
    m_case(8'h5A, 8'hC3, 1, 0, 2'd0);
    m_case(8'h01, 8'h80, 1, 1, 2'd2);
    // R4 rates
    for (int r = 0; r < 4; r++) begin
      m_xfer(8'h33, 8'h44, 0, 0, 2'(r), 1'b0, got, half);
      chk("R4 half period", half, exp_half(2'(r)));
      bread(2'd1, d); bread(2'd2, d);
    end
    // R11 read during a transfer returns the previous byte (0x44)
    bwrite(2'd0, 8'h53);
    miso_i = 1;
    bwrite(2'd2, 8'h00);
    repeat (40) @(negedge clk);
    bread(2'd2, d); chk("R11 mid-transfer read", d, 8'h44);
    repeat (300) @(negedge clk);
    bread(2'd1, d); bread(2'd2, d); chk("R11 new byte", d, 8'hFF);
    // R6 R7 flag clearing and interrupt
    m_xfer(8'h11, 8'h5A, 0, 0, 2'd0, 1'b1, got, half);
    chk("R7 irq set", irq, 1);
    bread(2'd2, d); chk("R6 data read alone", d, 8'h5A);
    bread(2'd1, d); chk("R6 flag still set", d, 8'h80);
    bread(2'd2, d);
    bread(2'd1, d); chk("R6 flag cleared", d, 8'h00);
    chk("R7 irq cleared", irq, 0);
    m_xfer(8'h22, 8'h66, 0, 0, 2'd0, 1'b0, got, half);
    chk("R7 irq masked", irq, 0);
    bread(2'd1, d); chk("R6 flag with ie off", d, 8'h80);
    bread(2'd2, d);
    // random master transfers
    for (int k = 0; k < 8; k++) begin
      logic [7:0] tx, sb;
      logic [3:0] mode;
      tx = 8'($urandom); sb = 8'($urandom); mode = 4'($urandom);
      m_case(tx, sb, mode[3], mode[2], mode[1:0]);
    end
    // R8 slave directed and random
    s_case(8'hC6, 8'h39, 0, 0);
    s_case(8'h9E, 8'h61, 0, 1);
    s_case(8'h0F, 8'hF0, 1, 0);
    s_case(8'hB4, 8'h2D, 1, 1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] pre, mb;
      logic [1:0] m;
      pre = 8'($urandom); mb = 8'($urandom); m = 2'($urandom);
      s_case(pre, mb, m[1], m[0]);
    end
    s_case(8'h12, 8'hE7, 0, 0);
    // R9 deselected slave ignores sck_i
    chk("R10 slave deselected miso_oe", miso_oe, 0);
    for (int i = 0; i < 16; i++) begin
      mosi_i = 1'($urandom);
      repeat (6) @(negedge clk);
      sck_i = ~sck_i;
    end
    repeat (8) @(negedge clk);
    bread(2'd1, d); chk("R9 no flag", d, 8'h00);
    bread(2'd2, d); chk("R9 buffer unchanged", d, 8'hE7);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule